// File: doc/BRIEF.md
# Byte-Addressed Seconds Counter

This block keeps a 32-bit count of elapsed seconds. The count advances by one on each single-cycle pulse of a 1 Hz tick input, but only while the counter enable bit in the control register is set. Software reaches the block through a narrow synchronous register port. The port has an 8-bit offset, 8-bit write data, a write strobe, a read strobe and registered 8-bit read data.

Software loads a new time one byte at a time. Bytes 1 to 3 are parked in holding registers. A write to byte 0 moves all four bytes into the counter in a single clock cycle, so a carry out of the low byte cannot corrupt a load that is only partly done. The live count is visible as four read bytes. Driver code detects a carry during a multi-byte read by re-reading the low byte. A fixed identification register tells software which kind of block it is talking to.

Top module: `secs_count_regs`

## Requirements
- R1: After reset the count is 0x00000000, the enable bit (bit 7 of offset 0x46) reads 1, and read data is 0x00.
- R2: While enabled, each cycle with the tick input high and no commit increments the 32-bit count by exactly one.
- R3: While the enable bit is 0, tick pulses leave the count unchanged.
- R4: Writes to offsets 0x41, 0x42 and 0x43 update only holding registers for count bytes 1, 2 and 3. The live count is not changed.
- R5: A write to offset 0x40 loads the count with {held byte 3, held byte 2, held byte 1, written byte} in one clock cycle.
- R6: When a tick and a commit write fall in the same cycle, the tick is dropped and the loaded value is kept.
- R7: Reads of offsets 0x48 to 0x4B return count bytes 0 to 3 of the live count, with byte 0 the least significant. Read data appears on the clock edge that samples the read strobe and holds until the next read.
- R8: Offset 0x46 holds the enable in bit 7. Writes to its other bits are ignored, and those bits read 0.
- R9: Offset 0x05 always reads 0x01.
- R10: Unmapped offsets and the write-only offsets 0x40 to 0x43 read 0x00. Writes to unmapped offsets change neither the count nor the enable.
- R11: The count wraps from 0xFFFFFFFF to 0x00000000 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle pulse once per second |
| busAddr | input | 8 | Register offset |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdata | output | 8 | Registered read data |

## Verification
The counter is first run with ticks while enabled and while disabled, which separates a counter that ignores the enable from one that ignores the tick. Loads stage distinct values in each holding byte (0x11, 0x22, 0x33, 0x44) before the commit, so a swapped byte lane or an early commit from an upper-byte write gives a wrong read. Tests then put a tick in the commit cycle, carry a low byte of 0xFF across a read to show the re-read check, and wrap the full count. A reset taken mid-run shows that the enable returns to 1 and the count returns to 0.

// File: rtl/secs_count_pkg.sv
package secs_count_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 4;
  localparam int CNT_W     = BYTE_W * NUM_BYTES;
  localparam int IDX_W     = $clog2(NUM_BYTES);

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_CNT  = 2'd1,
    RS_CTRL = 2'd2,
    RS_SUB  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BYTES-1:1] holdWr;
    logic                 commit;
    logic                 ctrlWr;
    logic                 rdEn;
    rdSel_e               rdSel;
    logic [IDX_W-1:0]     rdIdx;
  } strb_t;
endpackage

// File: rtl/secs_count_ctrl.sv
module secs_count_ctrl
  import secs_count_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WR_BASE  = 'h40,
  parameter int RD_BASE  = 'h48,
  parameter int CTRL_OFF = 'h46,
  parameter int SUB_OFF  = 'h05
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strb_t             strb
);
  always_comb begin
    strb        = '0;
    strb.rdSel  = RS_NONE;
    strb.rdEn   = busRd;
    if (busWr) begin
      if (busAddr == ADDR_W'(WR_BASE)) strb.commit = 1'b1;
      if (busAddr == ADDR_W'(CTRL_OFF)) strb.ctrlWr = 1'b1;
      for (int i = 1; i < NUM_BYTES; i++) begin
        if (busAddr == ADDR_W'(WR_BASE + i)) strb.holdWr[i] = 1'b1;
      end
    end
    if (busAddr == ADDR_W'(CTRL_OFF)) strb.rdSel = RS_CTRL;
    if (busAddr == ADDR_W'(SUB_OFF))  strb.rdSel = RS_SUB;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (busAddr == ADDR_W'(RD_BASE + i)) begin
        strb.rdSel = RS_CNT;
        strb.rdIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/secs_count_dp.sv
module secs_count_dp
  import secs_count_pkg::*;
#(
  parameter int               ENA_BIT    = 7,
  parameter logic [BYTE_W-1:0] SUBTYPE_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [BYTE_W-1:0] busWdata,
  input  strb_t             strb,
  output logic [BYTE_W-1:0] busRdata,
  output logic [CNT_W-1:0]  cntVal,
  output logic              enaVal
);
  logic [BYTE_W-1:0] holdQ [NUM_BYTES];
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  loadVal;
  logic              enaQ;
  logic [BYTE_W-1:0] rdNext;
  logic [BYTE_W-1:0] rdataQ;

  assign holdQ[0] = busWdata;

  for (genvar g = 1; g < NUM_BYTES; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)               holdQ[g] <= '0;
      else if (strb.holdWr[g]) holdQ[g] <= busWdata;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_load
    assign loadVal[g*BYTE_W +: BYTE_W] = holdQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      enaQ <= 1'b1;
    end else begin
      if (strb.commit)           cntQ <= loadVal;
      else if (tickIn && enaQ)   cntQ <= cntQ + 1'b1;
      if (strb.ctrlWr)           enaQ <= busWdata[ENA_BIT];
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strb.rdSel)
      RS_CNT:  rdNext = cntQ[strb.rdIdx*BYTE_W +: BYTE_W];
      RS_CTRL: rdNext[ENA_BIT] = enaQ;
      RS_SUB:  rdNext = SUBTYPE_ID;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdNext;
  end

  assign busRdata = rdataQ;
  assign cntVal   = cntQ;
  assign enaVal   = enaQ;
endmodule

// File: rtl/secs_count_regs.sv
module secs_count_regs
  import secs_count_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               WR_BASE    = 'h40,
  parameter int               RD_BASE    = 'h48,
  parameter int               CTRL_OFF   = 'h46,
  parameter int               SUB_OFF    = 'h05,
  parameter int               ENA_BIT    = 7,
  parameter logic [BYTE_W-1:0] SUBTYPE_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [BYTE_W-1:0] busRdata
);
  strb_t            strb;
  logic [CNT_W-1:0] cntVal;
  logic             enaVal;

  secs_count_ctrl #(
    .ADDR_W(ADDR_W), .WR_BASE(WR_BASE), .RD_BASE(RD_BASE),
    .CTRL_OFF(CTRL_OFF), .SUB_OFF(SUB_OFF)
  ) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  secs_count_dp #(
    .ENA_BIT(ENA_BIT), .SUBTYPE_ID(SUBTYPE_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busWdata(busWdata),
    .strb(strb), .busRdata(busRdata), .cntVal(cntVal), .enaVal(enaVal)
  );
endmodule

// File: rtl/secs_count_chk.sv
module secs_count_chk
  import secs_count_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               WR_BASE    = 'h40,
  parameter int               SUB_OFF    = 'h05,
  parameter logic [BYTE_W-1:0] SUBTYPE_ID = 8'h01
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWdata,
  input logic              busWr,
  input logic              busRd,
  input logic [BYTE_W-1:0] busRdata,
  input logic [CNT_W-1:0]  cntVal,
  input logic              enaVal
);
  logic commitNow;
  logic upperWr;
  assign commitNow = busWr && (busAddr == ADDR_W'(WR_BASE));
  assign upperWr   = busWr && (busAddr > ADDR_W'(WR_BASE)) &&
                     (busAddr < ADDR_W'(WR_BASE + NUM_BYTES));

  // R2 and R11: an enabled tick moves the count up by one, wrapping at the top
  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rstN)
    (enaVal && tickIn && !commitNow) |=> cntVal == $past(cntVal) + 1'b1);

  // R3: with the enable clear and no load, the count stays put
  a_r3_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enaVal && !commitNow) |=> $stable(cntVal));

  // R5 and R6: the committed low byte wins over any tick in the same cycle
  a_r5_commit_low: assert property (@(posedge clk) disable iff (!rstN)
    commitNow |=> cntVal[BYTE_W-1:0] == $past(busWdata));

  // R4: staging an upper byte never touches the live count
  a_r4_stage_only: assert property (@(posedge clk) disable iff (!rstN)
    (upperWr && !tickIn) |=> $stable(cntVal));

  // R9: the identification register is fixed
  a_r9_subtype: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(SUB_OFF)) |=> busRdata == SUBTYPE_ID);

  // R10: the top offset is unmapped
  a_r10_unmapped_rd: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == '1) |=> busRdata == '0);
  a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == '1 && !tickIn) |=> ($stable(cntVal) && $stable(enaVal)));
endmodule

bind secs_count_regs secs_count_chk #(
  .ADDR_W(ADDR_W), .WR_BASE(WR_BASE), .SUB_OFF(SUB_OFF), .SUBTYPE_ID(SUBTYPE_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr),
  .busWdata(busWdata), .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
  .cntVal(cntVal), .enaVal(enaVal)
);

// File: tb/sim_secs_count_regs.sv
module sim_secs_count_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdata;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  secs_count_regs u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr),
    .busWdata(busWdata), .busWr(busWr), .busRd(busRd), .busRdata(busRdata)
  );

  // op: 0 read+check, 1 write, 2 tick ; fields {op, req, addr, data, exp}
  localparam int NV = 32;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 4'd1,  8'h48, 8'h00, 8'h00},  // R1 count low byte after reset
    {2'd0, 4'd1,  8'h46, 8'h00, 8'h80},  // R1 enable set after reset
    {2'd0, 4'd9,  8'h05, 8'h00, 8'h01},  // R9 identification
    {2'd2, 4'd2,  8'h00, 8'h00, 8'h00},  // R2 tick
    {2'd2, 4'd2,  8'h00, 8'h00, 8'h00},
    {2'd2, 4'd2,  8'h00, 8'h00, 8'h00},
    {2'd0, 4'd2,  8'h48, 8'h00, 8'h03},  // R2 three ticks
    {2'd0, 4'd2,  8'h49, 8'h00, 8'h00},
    {2'd1, 4'd8,  8'h46, 8'h7F, 8'h00},  // R8 disable, other bits set
    {2'd0, 4'd8,  8'h46, 8'h00, 8'h00},  // R8 other bits read 0
    {2'd2, 4'd3,  8'h00, 8'h00, 8'h00},  // R3 tick while off
    {2'd0, 4'd3,  8'h48, 8'h00, 8'h03},  // R3 unchanged
    {2'd1, 4'd8,  8'h46, 8'h80, 8'h00},
    {2'd0, 4'd8,  8'h46, 8'h00, 8'h80},  // R8 re-enabled
    {2'd1, 4'd4,  8'h41, 8'h22, 8'h00},  // R4 stage bytes
    {2'd1, 4'd4,  8'h42, 8'h33, 8'h00},
    {2'd1, 4'd4,  8'h43, 8'h44, 8'h00},
    {2'd0, 4'd4,  8'h49, 8'h00, 8'h00},  // R4 live count untouched
    {2'd0, 4'd4,  8'h4B, 8'h00, 8'h00},
    {2'd0, 4'd4,  8'h48, 8'h00, 8'h03},
    {2'd1, 4'd5,  8'h40, 8'h11, 8'h00},  // R5 commit
    {2'd0, 4'd5,  8'h48, 8'h00, 8'h11},
    {2'd0, 4'd5,  8'h49, 8'h00, 8'h22},
    {2'd0, 4'd7,  8'h4A, 8'h00, 8'h33},  // R7 byte order
    {2'd0, 4'd7,  8'h4B, 8'h00, 8'h44},
    {2'd2, 4'd2,  8'h00, 8'h00, 8'h00},
    {2'd0, 4'd2,  8'h48, 8'h00, 8'h12},  // R2 after load
    {2'd0, 4'd10, 8'h41, 8'h00, 8'h00},  // R10 write-only reads 0
    {2'd1, 4'd10, 8'h20, 8'h55, 8'h00},  // R10 unmapped write
    {2'd0, 4'd10, 8'h20, 8'h00, 8'h00},
    {2'd0, 4'd10, 8'h48, 8'h00, 8'h12},  // R10 count unaffected
    {2'd0, 4'd10, 8'hFF, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic doTick();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R1", busRdata, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][29:28])
        2'd0: begin
          doRead(VEC[i][23:16], rd);
          check($sformatf("R%0d vec%0d", VEC[i][27:24], i), rd, VEC[i][7:0]);
        end
        2'd1: doWrite(VEC[i][23:16], VEC[i][15:8]);
        default: doTick();
      endcase
    end

    // R6: a tick in the commit cycle is dropped
    doWrite(8'h41, 8'h00);
    doWrite(8'h42, 8'h00);
    doWrite(8'h43, 8'h00);
    @(negedge clk);
    busAddr = 8'h40; busWdata = 8'h05; busWr = 1'b1; tickIn = 1'b1;
    @(negedge clk);
    busWr = 1'b0; tickIn = 1'b0;
    doRead(8'h48, rd);
    check("R6", rd, 8'h05);

    // R7: carry across a read, re-read of low byte shows it
    doWrite(8'h40, 8'hFF);
    doRead(8'h48, rd);
    check("R7 low before carry", rd, 8'hFF);
    doTick();
    doRead(8'h48, rd);
    check("R7 low after carry", rd, 8'h00);
    doRead(8'h49, rd);
    check("R7 byte1 after carry", rd, 8'h01);

    // R11: wrap of the full count
    doWrite(8'h41, 8'hFF);
    doWrite(8'h42, 8'hFF);
    doWrite(8'h43, 8'hFF);
    doWrite(8'h40, 8'hFF);
    doRead(8'h4B, rd);
    check("R11 top before wrap", rd, 8'hFF);
    doTick();
    for (int b = 0; b < 4; b++) begin
      doRead(8'h48 + 8'(b), rd);
      check($sformatf("R11 byte%0d after wrap", b), rd, 8'h00);
    end

    // R1: reset taken mid-run with enable cleared
    doWrite(8'h40, 8'h77);
    doWrite(8'h46, 8'h00);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    doRead(8'h46, rd);
    check("R1 enable after reset", rd, 8'h80);
    doRead(8'h48, rd);
    check("R1 count after reset", rd, 8'h00);

    summary();
  end
endmodule